// File: doc/BRIEF.md
# SMBus Bit-Level Master Engine

This block performs the lowest layer of an SMBus or I2C controller. It executes one bus primitive at a time on an open-drain clock line and data line: a START (which becomes a repeated START when a transaction is already open), a STOP, a single written bit, or a single read bit. A higher layer builds bytes, addresses and acknowledge handling from these primitives. Commands enter through a valid/ready handshake. Each command produces exactly one response pulse that carries an error code and a result bit.

The engine drives each line only by pulling it low. It observes the real line levels through a configurable synchronizer. All bus timing is a whole number of a single delay period, set in system clock cycles. A target may hold the clock low. Every clock release therefore waits for the line to go high, polling once per delay period. If the line stays low past a configurable number of polls, the engine forces a STOP and reports a timeout. A register tracks whether a transaction is open. This flag decides whether a START becomes a repeated START and whether a STOP has any effect.

Top module: `smbus_bit_master`

## Requirements
- R1: Command codes are 0 START, 1 STOP, 2 write bit, 3 read bit. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` then stays low until the cycle after the single `rsp_valid` pulse for that command. Error codes are 0 none, 1 timeout, 2 arbitration lost, 3 bus busy.
- R2: A START with no open transaction, seen while either line reads low, returns error 3. No pin changes, and the open flag stays clear.
- R3: A START from idle with both lines high first pulls the data line low. Exactly DELAY_CYCLES cycles later it pulls the clock low, giving line states (1,1),(1,0),(0,0) as (clock,data). In that same edge it sets the open flag and returns error 0.
- R4: A START with a transaction open releases data, waits one delay, releases the clock, waits for the clock to go high, and waits one delay. It then runs the R3 sequence. The full trace from idle is (1,1),(1,0),(0,0),(0,1),(1,1),(1,0),(0,0).
- R5: During a repeated START, if the data line reads low after the clock is high, the command returns error 2. It clears the open flag and leaves both lines released.
- R6: A write bit sets the data line to the bit value. It releases the clock exactly DELAY_CYCLES cycles later and pulls the clock low again after the clock-high wait and one delay. It returns error 0 and result bit 0.
- R7: Writing a 1 while the data line reads low at the sample point returns error 2. It clears the open flag and leaves the clock released.
- R8: A read bit releases the data line and pulses the clock. It returns the sampled data level on `rsp_bit` with error 0.
- R9: A target holding the clock low delays completion of a bit until the clock is seen high. If the clock is released before the poll limit, the command still returns error 0 and the transaction stays open.
- R10: If the clock is still low after STRETCH_POLLS polls, the engine issues a STOP when a transaction is open and returns error 1. The open flag ends clear and the data line ends released.
- R11: A STOP with a transaction open pulls data low, releases the clock, waits for it to go high, waits one delay, and releases data. After one further delay it clears the open flag and returns error 0. After a START the trace is (1,1),(1,0),(0,0),(1,0),(1,1).
- R12: A STOP with no open transaction changes no pin and returns error 0 on the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_op | input | 2 | Command code (see R1) |
| cmd_bit | input | 1 | Bit value for a write command |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 2 | Error code of the response |
| rsp_bit | output | 1 | Sampled data for a read, else 0 |
| xact_open | output | 1 | A transaction is open on the bus |
| scl_drive_low | output | 1 | Pull the clock line low when 1, release when 0 |
| sda_drive_low | output | 1 | Pull the data line low when 1, release when 0 |
| scl_in | input | 1 | Observed clock line level |
| sda_in | input | 1 | Observed data line level |

## Verification
The checker watches handshake discipline on every cycle. It also checks the end state each error code leaves behind: a busy error with untouched pins and a closed transaction, arbitration loss with both lines released, and timeout with data released and the transaction closed. It confirms that the open flag rises only with both lines pulled low and falls only with a response. The exact order and spacing of line transitions, the polling that absorbs clock stretching, and the sampled read values depend on what the target does on the bus. Only the bench's scenarios show these: it models an open-drain wired-AND bus with a target that can hold either line low and records every line change.

// File: rtl/smbm_pkg.sv
package smbm_pkg;
   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_STOP  = 2'd1,
      OP_WRITE = 2'd2,
      OP_READ  = 2'd3
   } smbm_op_e;

   typedef enum logic [1:0] {
      ERR_NONE    = 2'd0,
      ERR_TIMEOUT = 2'd1,
      ERR_ARB     = 2'd2,
      ERR_BUSY    = 2'd3
   } smbm_err_e;
endpackage

// File: rtl/smbm_sync.sv
module smbm_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '1;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/smbm_delay.sv
module smbm_delay #(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

   logic [CW-1:0] cnt_q;

   assign done = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!run || done)   cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/smbus_bit_master.sv
module smbus_bit_master
   import smbm_pkg::*;
#(
   parameter int DELAY_CYCLES  = 625,
   parameter int STRETCH_POLLS = 7000,
   parameter int SYNC_STAGES   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   output logic       cmd_ready,
   input  logic [1:0] cmd_op,
   input  logic       cmd_bit,
   output logic       rsp_valid,
   output logic [1:0] rsp_err,
   output logic       rsp_bit,
   output logic       xact_open,
   output logic       scl_drive_low,
   output logic       sda_drive_low,
   input  logic       scl_in,
   input  logic       sda_in
);
   localparam int PW = (STRETCH_POLLS > 1) ? $clog2(STRETCH_POLLS) : 1;
   localparam logic [PW-1:0] POLL_LAST = PW'(STRETCH_POLLS - 1);

   generate
      if (DELAY_CYCLES < 1) begin : g_bad_delay
         $error("DELAY_CYCLES must be at least 1");
      end
      if (STRETCH_POLLS < 1) begin : g_bad_polls
         $error("STRETCH_POLLS must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   typedef enum logic [3:0] {
      S_IDLE, S_ST_D, S_RS_D, S_BIT_D, S_STR_D, S_STR_CHK, S_STR_W,
      S_POST_D, S_SP_D1, S_SP_CHK, S_SP_W, S_SP_D2, S_SP_D3
   } state_e;

   state_e         state_q;
   smbm_op_e       op_q;
   smbm_err_e      err_pend_q;
   logic           bit_q;
   logic [PW-1:0]  poll_q;
   logic           scl_s, sda_s;
   logic           dly_run, dly_done;

   smbm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q({scl_s, sda_s})
   );

   always_comb begin
      case (state_q)
         S_ST_D, S_RS_D, S_BIT_D, S_STR_D, S_STR_W, S_POST_D,
         S_SP_D1, S_SP_W, S_SP_D2, S_SP_D3: dly_run = 1'b1;
         default:                           dly_run = 1'b0;
      endcase
   end

   smbm_delay #(.CYCLES(DELAY_CYCLES)) u_delay (
      .clk(clk), .rst_n(rst_n), .run(dly_run), .done(dly_done)
   );

   assign cmd_ready = (state_q == S_IDLE) && !rsp_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= S_IDLE;
         op_q          <= OP_START;
         err_pend_q    <= ERR_NONE;
         bit_q         <= 1'b0;
         poll_q        <= '0;
         scl_drive_low <= 1'b0;
         sda_drive_low <= 1'b0;
         xact_open     <= 1'b0;
         rsp_valid     <= 1'b0;
         rsp_err       <= ERR_NONE;
         rsp_bit       <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         case (state_q)
            S_IDLE: if (cmd_valid && cmd_ready) begin
               op_q  <= smbm_op_e'(cmd_op);
               bit_q <= cmd_bit;
               case (smbm_op_e'(cmd_op))
                  OP_START: begin
                     if (xact_open) begin
                        sda_drive_low <= 1'b0;
                        state_q       <= S_RS_D;
                     end else if (!scl_s || !sda_s) begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= ERR_BUSY;
                        rsp_bit   <= 1'b0;
                     end else begin
                        sda_drive_low <= 1'b1;
                        state_q       <= S_ST_D;
                     end
                  end
                  OP_STOP: begin
                     if (xact_open) begin
                        sda_drive_low <= 1'b1;
                        err_pend_q    <= ERR_NONE;
                        state_q       <= S_SP_D1;
                     end else begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= ERR_NONE;
                        rsp_bit   <= 1'b0;
                     end
                  end
                  OP_WRITE: begin
                     sda_drive_low <= ~cmd_bit;
                     state_q       <= S_BIT_D;
                  end
                  default: begin
                     sda_drive_low <= 1'b0;
                     state_q       <= S_BIT_D;
                  end
               endcase
            end
            S_ST_D: if (dly_done) begin
               scl_drive_low <= 1'b1;
               xact_open     <= 1'b1;
               rsp_valid     <= 1'b1;
               rsp_err       <= ERR_NONE;
               rsp_bit       <= 1'b0;
               state_q       <= S_IDLE;
            end
            S_RS_D, S_BIT_D: if (dly_done) begin
               scl_drive_low <= 1'b0;
               state_q       <= S_STR_D;
            end
            S_STR_D: if (dly_done) begin
               poll_q  <= '0;
               state_q <= S_STR_CHK;
            end
            S_STR_CHK: begin
               if (scl_s) begin
                  state_q <= S_POST_D;
               end else if (poll_q == POLL_LAST) begin
                  if (xact_open) begin
                     sda_drive_low <= 1'b1;
                     err_pend_q    <= ERR_TIMEOUT;
                     state_q       <= S_SP_D1;
                  end else begin
                     sda_drive_low <= 1'b0;
                     rsp_valid     <= 1'b1;
                     rsp_err       <= ERR_TIMEOUT;
                     rsp_bit       <= 1'b0;
                     state_q       <= S_IDLE;
                  end
               end else begin
                  poll_q  <= poll_q + 1'b1;
                  state_q <= S_STR_W;
               end
            end
            S_STR_W: if (dly_done) state_q <= S_STR_CHK;
            S_POST_D: if (dly_done) begin
               rsp_bit <= 1'b0;
               case (op_q)
                  OP_START: begin
                     if (!sda_s) begin
                        xact_open <= 1'b0;
                        rsp_valid <= 1'b1;
                        rsp_err   <= ERR_ARB;
                        state_q   <= S_IDLE;
                     end else begin
                        sda_drive_low <= 1'b1;
                        state_q       <= S_ST_D;
                     end
                  end
                  OP_WRITE: begin
                     rsp_valid <= 1'b1;
                     state_q   <= S_IDLE;
                     if (bit_q && !sda_s) begin
                        xact_open <= 1'b0;
                        rsp_err   <= ERR_ARB;
                     end else begin
                        scl_drive_low <= 1'b1;
                        rsp_err       <= ERR_NONE;
                     end
                  end
                  default: begin
                     scl_drive_low <= 1'b1;
                     rsp_valid     <= 1'b1;
                     rsp_err       <= ERR_NONE;
                     rsp_bit       <= sda_s;
                     state_q       <= S_IDLE;
                  end
               endcase
            end
            S_SP_D1: if (dly_done) begin
               scl_drive_low <= 1'b0;
               poll_q        <= '0;
               state_q       <= S_SP_CHK;
            end
            S_SP_CHK: begin
               if (scl_s || poll_q == POLL_LAST) begin
                  state_q <= S_SP_D2;
               end else begin
                  poll_q  <= poll_q + 1'b1;
                  state_q <= S_SP_W;
               end
            end
            S_SP_W: if (dly_done) state_q <= S_SP_CHK;
            S_SP_D2: if (dly_done) begin
               sda_drive_low <= 1'b0;
               state_q       <= S_SP_D3;
            end
            S_SP_D3: if (dly_done) begin
               xact_open <= 1'b0;
               rsp_valid <= 1'b1;
               rsp_err   <= err_pend_q;
               rsp_bit   <= 1'b0;
               state_q   <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/smbm_master_chk.sv
module smbm_master_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic       cmd_ready,
   input logic       rsp_valid,
   input logic [1:0] rsp_err,
   input logic       xact_open,
   input logic       scl_drive_low,
   input logic       sda_drive_low
);
   p_accept_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready |=> !cmd_ready);

   p_rsp_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   p_busy_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_err == 2'd3 |->
         !xact_open && $stable(scl_drive_low) && $stable(sda_drive_low));

   p_open_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xact_open) |->
         rsp_valid && rsp_err == 2'd0 && scl_drive_low && sda_drive_low);

   p_arb_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_err == 2'd2 |->
         !xact_open && !scl_drive_low && !sda_drive_low);

   p_timeout_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_err == 2'd1 |-> !xact_open && !sda_drive_low);

   p_close_with_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xact_open) |-> rsp_valid);
endmodule

bind smbus_bit_master smbm_master_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .rsp_valid(rsp_valid), .rsp_err(rsp_err), .xact_open(xact_open),
   .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
);

// File: tb/smbus_bit_master_tb.sv
module smbus_bit_master_tb;
   localparam int DLY   = 4;
   localparam int POLLS = 6;
   localparam int SYNC  = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_op = 2'd0;
   logic       cmd_bit = 1'b0;
   logic       cmd_ready, rsp_valid, rsp_bit, xact_open;
   logic [1:0] rsp_err;
   logic       scl_drive_low, sda_drive_low;
   logic       slv_scl_low = 1'b0, slv_sda_low = 1'b0;
   logic       scl_line, sda_line;

   assign scl_line = ~(scl_drive_low | slv_scl_low);
   assign sda_line = ~(sda_drive_low | slv_sda_low);

   smbus_bit_master #(.DELAY_CYCLES(DLY), .STRETCH_POLLS(POLLS),
                      .SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_bit(cmd_bit), .rsp_valid(rsp_valid),
      .rsp_err(rsp_err), .rsp_bit(rsp_bit), .xact_open(xact_open),
      .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
      .scl_in(scl_line), .sda_in(sda_line)
   );

   int total = 0, bad = 0;
   int cyc = 0;
   int last_rsp_cyc = 0;
   int rel_cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      logic [1:0] err;
      logic       b;
      string      tag;
   } exp_t;
   exp_t exp_q[$];
   exp_t e;

   logic [1:0] hist [64];
   int         hstamp [64];
   int         hcnt = 1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // monitor: line-change recorder and response scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (hcnt < 64 && {scl_line, sda_line} != hist[hcnt-1]) begin
            hist[hcnt]   = {scl_line, sda_line};
            hstamp[hcnt] = cyc;
            hcnt++;
         end
         if (rsp_valid) begin
            last_rsp_cyc = cyc;
            if (exp_q.size() == 0) begin
               check(1'b0, "R1", "unexpected response", 1, 0);
            end else begin
               e = exp_q.pop_front();
               check(rsp_err == e.err, e.tag, "error code", rsp_err, e.err);
               check(rsp_bit == e.b, e.tag, "result bit", rsp_bit, e.b);
            end
         end
      end
   end

   task automatic issue(input logic [1:0] op, input logic b,
                        input logic [1:0] xerr, input logic xbit,
                        input string tag);
      exp_t item;
      item.err = xerr; item.b = xbit; item.tag = tag;
      exp_q.push_back(item);
      cmd_op = op; cmd_bit = b; cmd_valid = 1'b1;
      forever begin
         @(negedge clk);
         if (cmd_ready) break;
      end
      @(posedge clk); #2;
      cmd_valid = 1'b0;
      check(cmd_ready == 1'b0, "R1", "ready after accept", cmd_ready, 0);
      while (exp_q.size() != 0) @(negedge clk);
      @(posedge clk); #2;
   endtask

   task automatic trace_reset();
      hist[0]   = {scl_line, sda_line};
      hstamp[0] = cyc;
      hcnt      = 1;
   endtask

   task automatic trace_expect(input int n, input logic [31:0] v, input string tag);
      check(hcnt == n, tag, "trace length", hcnt, n);
      for (int i = 0; i < n; i++) begin
         if (i < hcnt)
            check(hist[i] == v[2*(n-1-i) +: 2], tag, "trace state",
                  hist[i], v[2*(n-1-i) +: 2]);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   initial begin
      #(8 * 100000);
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      hist[0] = 2'b11;
      idle(5);
      rst_n = 1'b1;
      @(negedge clk);
      check(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);
      check(xact_open == 1'b0, "R1", "open after reset", xact_open, 0);
      check(scl_drive_low == 1'b0 && sda_drive_low == 1'b0, "R1",
            "pins after reset", {scl_drive_low, sda_drive_low}, 0);
      idle(2);

      // R12: STOP with nothing open
      trace_reset();
      issue(2'd1, 1'b0, 2'd0, 1'b0, "R12");
      trace_expect(1, {2'b11}, "R12");

      // R2: START while data held low by a target
      slv_sda_low = 1'b1;
      idle(4);
      trace_reset();
      issue(2'd0, 1'b0, 2'd3, 1'b0, "R2");
      check(xact_open == 1'b0, "R2", "open after busy", xact_open, 0);
      trace_expect(1, {2'b10}, "R2");
      slv_sda_low = 1'b0;
      idle(4);

      // R3, R11: START then STOP
      trace_reset();
      issue(2'd0, 1'b0, 2'd0, 1'b0, "R3");
      check(xact_open == 1'b1, "R3", "open after start", xact_open, 1);
      issue(2'd1, 1'b0, 2'd0, 1'b0, "R11");
      check(xact_open == 1'b0, "R11", "open after stop", xact_open, 0);
      trace_expect(5, {2'b11, 2'b10, 2'b00, 2'b10, 2'b11}, "R11");
      check(hstamp[2] - hstamp[1] == DLY, "R3", "data-to-clock spacing",
            hstamp[2] - hstamp[1], DLY);

      // R4: START then repeated START
      trace_reset();
      issue(2'd0, 1'b0, 2'd0, 1'b0, "R4");
      issue(2'd0, 1'b0, 2'd0, 1'b0, "R4");
      trace_expect(7, {2'b11, 2'b10, 2'b00, 2'b01, 2'b11, 2'b10, 2'b00}, "R4");
      check(xact_open == 1'b1, "R4", "open after repeated start", xact_open, 1);

      // R6: write 0 then write 1
      trace_reset();
      issue(2'd2, 1'b0, 2'd0, 1'b0, "R6");
      issue(2'd2, 1'b1, 2'd0, 1'b0, "R6");
      trace_expect(6, {2'b00, 2'b10, 2'b00, 2'b01, 2'b11, 2'b01}, "R6");
      check(hstamp[4] - hstamp[3] == DLY, "R6", "data setup before clock",
            hstamp[4] - hstamp[3], DLY);

      // R8: read with target driving 0, then released (1)
      slv_sda_low = 1'b1;
      issue(2'd3, 1'b0, 2'd0, 1'b0, "R8");
      slv_sda_low = 1'b0;
      issue(2'd3, 1'b0, 2'd0, 1'b1, "R8");
      issue(2'd1, 1'b0, 2'd0, 1'b0, "R11");
      idle(3);

      // R7: written 1 overridden by a target
      issue(2'd0, 1'b0, 2'd0, 1'b0, "R7");
      slv_sda_low = 1'b1;
      issue(2'd2, 1'b1, 2'd2, 1'b0, "R7");
      check(xact_open == 1'b0, "R7", "open after arbitration loss", xact_open, 0);
      check(scl_drive_low == 1'b0, "R7", "clock left released", scl_drive_low, 0);
      slv_sda_low = 1'b0;
      idle(4);

      // R5: repeated START with data held low
      issue(2'd0, 1'b0, 2'd0, 1'b0, "R5");
      slv_sda_low = 1'b1;
      issue(2'd0, 1'b0, 2'd2, 1'b0, "R5");
      check(xact_open == 1'b0, "R5", "open after arbitration loss", xact_open, 0);
      check(scl_drive_low == 1'b0 && sda_drive_low == 1'b0, "R5",
            "lines released", {scl_drive_low, sda_drive_low}, 0);
      slv_sda_low = 1'b0;
      idle(4);

      // R9: clock stretched for a while, then released
      issue(2'd0, 1'b0, 2'd0, 1'b0, "R9");
      slv_scl_low = 1'b1;
      fork
         begin
            repeat (15) @(posedge clk);
            #2;
            slv_scl_low = 1'b0;
            rel_cyc = cyc;
         end
      join_none
      issue(2'd2, 1'b0, 2'd0, 1'b0, "R9");
      check(last_rsp_cyc >= rel_cyc + SYNC, "R9", "completion after release",
            last_rsp_cyc, rel_cyc + SYNC);
      check(xact_open == 1'b1, "R9", "open after stretched bit", xact_open, 1);

      // R10: clock held low past the poll limit
      slv_scl_low = 1'b1;
      issue(2'd2, 1'b1, 2'd1, 1'b0, "R10");
      check(xact_open == 1'b0, "R10", "open after timeout", xact_open, 0);
      check(sda_drive_low == 1'b0, "R10", "data released", sda_drive_low, 0);
      check(scl_drive_low == 1'b0, "R10", "clock released", scl_drive_low, 0);
      slv_scl_low = 1'b0;
      idle(6);

      // bus usable again after timeout
      issue(2'd0, 1'b0, 2'd0, 1'b0, "R3");
      issue(2'd1, 1'b0, 2'd0, 1'b0, "R11");
      check(exp_q.size() == 0, "R1", "pending responses", exp_q.size(), 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule